// File: doc/BRIEF.md
# Display Bias Rail Sequencer

This controller decides, cycle by cycle, which of five supply rails of a display bias supply are enabled. It takes two enable requests from the system, a flag that says the input supply is above its undervoltage lockout level, a per-rail "reached 90% of target" flag, a "negative gate rail has decayed below 30%" flag and four fault flags. It drives one enable per rail, an active-low fault indication and a sleep indication. The analog regulators, comparators and charge pumps sit outside and are seen only through these flags.

The core request powers only the logic rail. The group request powers the other four rails, in a fixed order, each waiting for the one before it to reach its threshold. Shutdown runs in the reverse order. The logic rail goes off last, and only after the negative gate rail has decayed or a time-out counter has expired. Requests that arrive in the wrong order are held off until the ordering conditions allow them. The request and comparator inputs pass through synchronizers. The fault flags are taken as synchronous to the clock and act on the next edge.

Top module: `rail_seq_ctrl`

## Requirements
- R1: After reset, `sleep` is 1, `rail_en` is 00000 and `fault_n` is 1. Enable bit positions are: bit 0 logic rail, bit 1 analog rail, bit 2 negative gate rail, bit 3 positive gate rail, bit 4 common reference rail.
- R2: While the synchronized `uvlo_clr` is low, `rail_en` stays 00000 and `sleep` stays 1, and both requests are ignored. Once `uvlo_clr` is high, requests that are already high take effect.
- R3: With `req_core` high and `req_grp` low, only bit 0 of `rail_en` is set.
- R4: A high `req_grp` has no effect until bit 0 is enabled and `rail_hi[0]` is high.
- R5: At startup, bit k (k = 1..4) is set only while bit k-1 is set, and only after `rail_hi[k-1]` was seen high. A rail whose `rail_hi` stays low stops the sequence at that rail.
- R6: A fall of `req_core` while `req_grp` is high is ignored, and all rails stay enabled.
- R7: Bit 0 is cleared only after bits 1..4 are all clear and either `neg_lo` is seen high or TMO_CYC cycles have elapsed since bit 2 was cleared.
- R8: When `req_grp` falls, bits 4, 3, 2, 1 are cleared in that order, one per cycle. Bit 0 stays set if `req_core` is still high.
- R9: Any set bit of `fault_in` (bit 0 overcurrent, 1 overvoltage, 2 short circuit, 3 thermal overload) clears all of `rail_en` and drives `fault_n` low on the next clock edge. The fault state is held until both requests are seen low, and then `fault_n` returns to 1.
- R10: If `uvlo_clr` falls at any time, the block returns to sleep with all rails disabled.
- R11: A request rising from the off state sets bit 0 at the third rising clock edge after the change (two synchronizer stages plus the state register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_core | input | 1 | Enable request for the logic rail |
| req_grp | input | 1 | Enable request for the four remaining rails |
| uvlo_clr | input | 1 | Input supply above the lockout level |
| rail_hi | input | 5 | Per-rail flag: output above 90% of target |
| neg_lo | input | 1 | Negative gate rail below 30% of target |
| fault_in | input | 4 | Overcurrent, overvoltage, short-circuit and thermal flags |
| rail_en | output | 5 | Per-rail enable |
| fault_n | output | 1 | Active-low fault indication |
| sleep | output | 1 | High while in the lockout sleep state |

## Verification
The bench builds the block with TMO_CYC = 16 and SYNC_STAGES = 2. The short time-out lets a shutdown with the negative rail held high run into its time-out within a few dozen cycles, so both the early window (logic rail still on) and the late window (logic rail off) can be observed. With two synchronizer stages the request-to-enable latency is exactly three edges, and the bench checks that cycle directly. The bench models each rail's 90% flag as following its own enable, with a mask to hold selected rails low, so stuck-rail and out-of-order cases arise from ordinary stimulus.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  localparam int NRAIL = 5;
  localparam int NFLT  = 4;

  typedef enum logic [3:0] {
    ST_SLEEP,
    ST_OFF,
    ST_CUP,
    ST_CON,
    ST_GUP,
    ST_ALL,
    ST_GDN,
    ST_DRN,
    ST_FLT
  } seq_st_e;

  // any fault flag raised
  function automatic logic any_fault(input logic [NFLT-1:0] f);
    return |f;
  endfunction

  // enables form a contiguous run starting at bit 0
  function automatic logic is_prefix(input logic [NRAIL-1:0] m);
    return (m & (m + 1'b1)) == '0;
  endfunction

  // time-out reached
  function automatic logic tmo_hit(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign d_out = stg_q[STAGES-1];

endmodule

// File: rtl/shdn_timer.sv
module shdn_timer #(
  parameter int TMO_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clr,
  output logic expired
);
  import rail_seq_pkg::*;

  localparam int CW = $clog2(TMO_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q && !tmo_hit(int'(cnt_q), TMO_CYC)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = run_q && tmo_hit(int'(cnt_q), TMO_CYC);

  // R7
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= TMO_CYC);

  // R7
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> cnt_q == '0);

endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
  import rail_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_a_s,
  input  logic             req_b_s,
  input  logic             uvlo_s,
  input  logic [NRAIL-1:0] hi_s,
  input  logic             neg_lo_s,
  input  logic [NFLT-1:0]  fault_in,
  input  logic             tmo_exp,
  output logic             tmr_start,
  output logic             tmr_clr,
  output logic [NRAIL-1:0] rail_en,
  output logic             fault_n,
  output logic             sleep
);

  localparam int IW = $clog2(NRAIL);
  localparam logic [IW-1:0] IDX_TOP = IW'(NRAIL - 1);
  localparam logic [IW-1:0] IDX_NEG = IW'(2);
  localparam logic [IW-1:0] IDX_ONE = IW'(1);

  seq_st_e          st_q, st_d;
  logic [NRAIL-1:0] en_q, en_d;
  logic [IW-1:0]    idx_q, idx_d;

  // named internal events
  logic flt_evt;
  logic drain_done;
  logic grp_last;

  assign flt_evt    = any_fault(fault_in);
  assign drain_done = (st_q == ST_DRN) && (neg_lo_s || tmo_exp);
  assign grp_last   = (idx_q == IDX_TOP) && hi_s[idx_q];
  assign tmr_start  = (st_q == ST_GDN) && (idx_q == IDX_NEG);
  assign tmr_clr    = ((st_q != ST_GDN) && (st_q != ST_DRN)) || drain_done;

  always_comb begin
    st_d  = st_q;
    en_d  = en_q;
    idx_d = idx_q;
    if (!uvlo_s) begin
      st_d = ST_SLEEP;
      en_d = '0;
    end else if (flt_evt && st_q != ST_SLEEP) begin
      st_d = ST_FLT;
      en_d = '0;
    end else begin
      unique case (st_q)
        ST_SLEEP: st_d = ST_OFF;
        ST_OFF: begin
          if (req_a_s) begin
            st_d    = ST_CUP;
            en_d[0] = 1'b1;
          end
        end
        ST_CUP: begin
          if (!req_a_s) begin
            st_d    = ST_OFF;
            en_d[0] = 1'b0;
          end else if (hi_s[0]) begin
            st_d = ST_CON;
          end
        end
        ST_CON: begin
          if (!req_a_s) begin
            st_d    = ST_OFF;
            en_d[0] = 1'b0;
          end else if (req_b_s) begin
            st_d    = ST_GUP;
            idx_d   = IDX_ONE;
            en_d[1] = 1'b1;
          end
        end
        ST_GUP: begin
          if (!req_b_s) begin
            st_d  = ST_GDN;
            idx_d = IDX_TOP;
          end else if (grp_last) begin
            st_d = ST_ALL;
          end else if (hi_s[idx_q]) begin
            idx_d       = idx_q + 1'b1;
            en_d[idx_d] = 1'b1;
          end
        end
        ST_ALL: begin
          if (!req_b_s) begin
            st_d  = ST_GDN;
            idx_d = IDX_TOP;
          end
        end
        ST_GDN: begin
          en_d[idx_q] = 1'b0;
          if (idx_q == IDX_ONE) st_d = ST_DRN;
          else                  idx_d = idx_q - 1'b1;
        end
        ST_DRN: begin
          if (drain_done) begin
            if (req_a_s) begin
              st_d = ST_CON;
            end else begin
              st_d    = ST_OFF;
              en_d[0] = 1'b0;
            end
          end
        end
        ST_FLT: begin
          if (!req_a_s && !req_b_s) st_d = ST_OFF;
        end
        default: begin
          st_d = ST_SLEEP;
          en_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_SLEEP;
      en_q  <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      en_q  <= en_d;
      idx_q <= idx_d;
    end
  end

  assign rail_en = en_q;
  assign fault_n = (st_q != ST_FLT);
  assign sleep   = (st_q == ST_SLEEP);

  // R2 R10
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !uvlo_s |=> (rail_en == '0) && sleep);

  // R9
  flt_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo_s && flt_evt) |=> (rail_en == '0) && !fault_n);

  // R9
  flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && uvlo_s && (req_a_s || req_b_s)) |=> !fault_n);

  // R7
  core_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_en[0]) |-> rail_en[NRAIL-1:1] == '0);

  // R7
  core_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rail_en[0]) && $past(st_q == ST_DRN)) |-> $past(neg_lo_s || tmo_exp));

  // R4
  grp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en[1]) |-> $past(hi_s[0] && rail_en[0]));

  genvar k;
  generate
    for (k = 1; k < NRAIL; k++) begin : g_ord
      // R5
      up_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en[k]) |-> rail_en[k-1]);
      // R8
      if (k < NRAIL - 1) begin : g_dn
        dn_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
          $fell(rail_en[k]) |-> rail_en[NRAIL-1:k+1] == '0);
      end
    end
  endgenerate

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
#(
  parameter int TMO_CYC     = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_core,
  input  logic             req_grp,
  input  logic             uvlo_clr,
  input  logic [NRAIL-1:0] rail_hi,
  input  logic             neg_lo,
  input  logic [NFLT-1:0]  fault_in,
  output logic [NRAIL-1:0] rail_en,
  output logic             fault_n,
  output logic             sleep
);

  localparam int SW = NRAIL + 4;

  logic [SW-1:0]    raw_in, syn_out;
  logic             req_a_s, req_b_s, uvlo_s, neg_lo_s;
  logic [NRAIL-1:0] hi_s;
  logic             tmr_start, tmr_clr, tmo_exp;

  assign raw_in = {neg_lo, rail_hi, uvlo_clr, req_grp, req_core};

  sync_bank #(.WIDTH(SW), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (raw_in),
    .d_out (syn_out)
  );

  assign req_a_s  = syn_out[0];
  assign req_b_s  = syn_out[1];
  assign uvlo_s   = syn_out[2];
  assign hi_s     = syn_out[NRAIL+2:3];
  assign neg_lo_s = syn_out[SW-1];

  shdn_timer #(.TMO_CYC(TMO_CYC)) tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .clr     (tmr_clr),
    .expired (tmo_exp)
  );

  rail_seq_fsm fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_a_s   (req_a_s),
    .req_b_s   (req_b_s),
    .uvlo_s    (uvlo_s),
    .hi_s      (hi_s),
    .neg_lo_s  (neg_lo_s),
    .fault_in  (fault_in),
    .tmo_exp   (tmo_exp),
    .tmr_start (tmr_start),
    .tmr_clr   (tmr_clr),
    .rail_en   (rail_en),
    .fault_n   (fault_n),
    .sleep     (sleep)
  );

  // R1 R5 R8
  prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_prefix(rail_en));

endmodule

// File: tb/rail_seq_ctrl_tb_top.sv
module rail_seq_ctrl_tb_top;

  localparam int CLK_PER = 10;
  localparam int TMO     = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_core = 1'b0, req_grp = 1'b0, uvlo_clr = 1'b0;
  logic [4:0] blk = 5'b0;
  logic       lo_hold = 1'b0;
  logic [3:0] fault_in = 4'b0;
  logic [4:0] rail_hi;
  logic       neg_lo;
  logic [4:0] rail_en;
  logic       fault_n, sleep;

  int total = 0;
  int bad = 0;
  int order_bad = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  // rail model: a rail reaches 90% as soon as it is enabled unless masked
  assign rail_hi = rail_en & ~blk;
  assign neg_lo  = lo_hold ? 1'b0 : !rail_en[2];

  rail_seq_ctrl #(.TMO_CYC(TMO), .SYNC_STAGES(2)) dut_i (
    .clk (clk), .rst_n (rst_n), .req_core (req_core), .req_grp (req_grp),
    .uvlo_clr (uvlo_clr), .rail_hi (rail_hi), .neg_lo (neg_lo),
    .fault_in (fault_in), .rail_en (rail_en), .fault_n (fault_n), .sleep (sleep)
  );

  typedef struct packed {
    logic       uv, a, b;
    logic [4:0] blk;
    logic       lh;
    logic [3:0] flt;
    logic [7:0] wt;
    logic [4:0] een;
    logic       efn, esl;
    logic [3:0] tag;
  } row_t;

  localparam row_t TBL [16] = '{
    '{1'b0,1'b1,1'b1,5'b00000,1'b0,4'h0,8'd10,5'b00000,1'b1,1'b1,4'd2},  // R2 sleep ignores
    '{1'b1,1'b1,1'b1,5'b00001,1'b0,4'h0,8'd10,5'b00001,1'b1,1'b0,4'd4},  // R4 core not up
    '{1'b1,1'b1,1'b1,5'b00000,1'b0,4'h0,8'd20,5'b11111,1'b1,1'b0,4'd5},  // R5 full start
    '{1'b1,1'b0,1'b1,5'b00000,1'b0,4'h0,8'd20,5'b11111,1'b1,1'b0,4'd6},  // R6 core fall ignored
    '{1'b1,1'b0,1'b0,5'b00000,1'b1,4'h0,8'd10,5'b00001,1'b1,1'b0,4'd7},  // R7 core waits
    '{1'b1,1'b0,1'b0,5'b00000,1'b1,4'h0,8'd30,5'b00000,1'b1,1'b0,4'd7},  // R7 time-out
    '{1'b1,1'b1,1'b0,5'b00000,1'b0,4'h0,8'd20,5'b00001,1'b1,1'b0,4'd3},  // R3 core only
    '{1'b1,1'b1,1'b1,5'b01000,1'b0,4'h0,8'd20,5'b01111,1'b1,1'b0,4'd5},  // R5 stuck rail
    '{1'b1,1'b1,1'b1,5'b00000,1'b0,4'h0,8'd20,5'b11111,1'b1,1'b0,4'd5},  // R5 resume
    '{1'b1,1'b1,1'b0,5'b00000,1'b0,4'h0,8'd20,5'b00001,1'b1,1'b0,4'd8},  // R8 core kept
    '{1'b1,1'b1,1'b1,5'b00000,1'b0,4'h1,8'd3, 5'b00000,1'b0,1'b0,4'd9},  // R9 overcurrent
    '{1'b1,1'b1,1'b0,5'b00000,1'b0,4'h0,8'd10,5'b00000,1'b0,1'b0,4'd9},  // R9 latched
    '{1'b1,1'b0,1'b0,5'b00000,1'b0,4'h0,8'd10,5'b00000,1'b1,1'b0,4'd9},  // R9 released
    '{1'b1,1'b1,1'b1,5'b00000,1'b0,4'h0,8'd30,5'b11111,1'b1,1'b0,4'd5},  // R5 restart
    '{1'b0,1'b1,1'b1,5'b00000,1'b0,4'h0,8'd10,5'b00000,1'b1,1'b1,4'd10}, // R10 lockout
    '{1'b1,1'b1,1'b1,5'b00000,1'b0,4'h0,8'd30,5'b11111,1'b1,1'b0,4'd2}   // R2 resume
  };

  task automatic check(input bit ok, input string req, input logic [6:0] act,
                       input logic [6:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [4:0] en,
                            input logic fn, input logic sl);
    check({rail_en, fault_n, sleep} == {en, fn, sl}, req,
          {rail_en, fault_n, sleep}, {en, fn, sl});
  endtask

  // R5 R8: enables always form a run from bit 0
  always @(negedge clk)
    if (rst_n && ((rail_en & (rail_en + 5'd1)) != 5'd0)) order_bad++;

  initial begin
    cyc(3);
    expect_out("R1", 5'b00000, 1'b1, 1'b1);
    rst_n = 1'b1;
    cyc(2);
    expect_out("R1", 5'b00000, 1'b1, 1'b1);
    uvlo_clr = 1'b1;
    cyc(6);
    // R11 latency from the off state
    req_core = 1'b1;
    cyc(1);
    check(rail_en[0] == 1'b0, "R11", {6'b0, rail_en[0]}, 7'd0);
    cyc(1);
    check(rail_en[0] == 1'b0, "R11", {6'b0, rail_en[0]}, 7'd0);
    cyc(1);
    check(rail_en[0] == 1'b1, "R11", {6'b0, rail_en[0]}, 7'd1);
    req_core = 1'b0;
    cyc(10);
    expect_out("R3", 5'b00000, 1'b1, 1'b0);

    for (int i = 0; i < 16; i++) begin
      uvlo_clr = TBL[i].uv;
      req_core = TBL[i].a;
      req_grp  = TBL[i].b;
      blk      = TBL[i].blk;
      lo_hold  = TBL[i].lh;
      fault_in = TBL[i].flt;
      cyc(int'(TBL[i].wt));
      expect_out($sformatf("R%0d row%0d", TBL[i].tag, i),
                 TBL[i].een, TBL[i].efn, TBL[i].esl);
    end

    // R9: each fault source on its own
    for (int f = 0; f < 4; f++) begin
      fault_in = 4'(1 << f);
      cyc(2);
      expect_out("R9", 5'b00000, 1'b0, 1'b0);
      fault_in = 4'b0;
      req_core = 1'b0;
      req_grp  = 1'b0;
      cyc(10);
      expect_out("R9", 5'b00000, 1'b1, 1'b0);
      req_core = 1'b1;
      req_grp  = 1'b1;
      cyc(30);
      expect_out("R5", 5'b11111, 1'b1, 1'b0);
    end

    // R8: shutdown order observed over the whole run
    check(order_bad == 0, "R8", 7'(order_bad), 7'd0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule